// File: doc/BRIEF.md
# Bitmask Dictionary Compressor With Run-Length Repeats

This block compresses a stream of 8-bit test words. Each word comes with a care mask, and any bit whose care bit is 0 is a don't-care. Every word is compared against two dictionary entries held in registers, and the block emits one variable-length code. The code is a direct match, a match after flipping one 2-bit window, or an uncompressed literal. When words repeat, the first occurrence is coded normally. The repeats that follow are folded into a single run-length code. That code reuses the bitmask format with its otherwise impossible all-zero pattern, so a repeat needs no extra format bit.

Codes leave through a registered output stage with a valid/ready handshake. The input side also uses a valid/ready handshake. A code is right-aligned in `out_code`. Its `out_len` valid bits are sent most significant first, and the bits above them are zero. The dictionary is written through a small configuration port. An end-of-stream flag on the input word closes any open run.

The controller has three states:
- `ST_EMPTY`: no run is open. Accepting a word emits its code. The transition is to `ST_RUN`, or back to `ST_EMPTY` when the word carries the end flag.
- `ST_RUN`: a head code is open. A repeat either increments the count or, at the limit, emits a full run code. A different word arriving while the count is 0 emits that word's code and becomes the new head. A different word arriving while the count is nonzero moves the controller to `ST_FLUSH` without consuming the word. An end flag on a repeat moves the controller to `ST_FLUSH`, or to `ST_EMPTY` if the limit was just reached.
- `ST_FLUSH`: the pending repeats are emitted, either as one run code or as individual copies of the head. The controller then returns to `ST_EMPTY`.

Top module: `bmrle_encoder`

## Requirements
- R1: A word that fits no dictionary entry in any form is emitted as a 9-bit literal: a leading 1 followed by the 8 data bits, with don't-care bits sent as 0.
- R2: A word compatible with an entry is emitted as 3 bits `0,1,idx`. Entry 0 wins over entry 1.
- R3: A word is compatible with an entry when every cared bit equals that entry. Don't-care bits never cause a mismatch, and they never break a repeat.
- R4: A word that differs from an entry only inside one aligned 2-bit window is emitted as 7 bits `0,0,pos[1:0],pat[1:0],idx`. Position 0 is bits 7:6 and position 3 is bits 1:0. The pattern is entry XOR word within the window. The lowest position is tried first, and within a position entry 0 is tried before entry 1.
- R5: A word whose code equals that of the open run's head counts as a repeat. Repeats are emitted as a 7-bit run code `0,0,c[2:1],00,c[0]`, where c is the repeat count.
- R6: Pending repeats use a run code only if n times the head length exceeds 7. Otherwise the head code is emitted again n times.
- R7: The count runs from 1 to 7. The seventh pending repeat emits a run code of 7 at once, and later repeats start a new count.
- R8: Pending repeats are flushed before the code of a different word, and after a word carrying the end flag. An end flag also closes the run, so the next word starts fresh.
- R9: While `out_valid` is high and `out_ready` is low, the output code and length hold steady. No code is lost or duplicated under any pattern of backpressure.
- R10: Raising `cfg_we` loads `cfg_word` into the entry selected by `cfg_sel`.
- R11: After reset `out_valid` is 0, `in_ready` is 1 and both entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Dictionary write strobe |
| cfg_sel | input | 1 | Dictionary entry to write |
| cfg_word | input | 8 | Value written to the entry |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle |
| in_data | input | 8 | Test word |
| in_care | input | 8 | Per-bit care mask, 1 means the bit matters |
| in_last | input | 1 | Final word of the stream |
| out_valid | output | 1 | Code present |
| out_ready | input | 1 | Consumer accepts the code |
| out_code | output | 9 | Code, right-aligned |
| out_len | output | 4 | Number of valid code bits (3, 7 or 9) |

## Verification
Two functions can coincide in one cycle. The seventh pending repeat may saturate the count on the same word that carries the end flag. The run code of 7 must then be emitted and the run closed together, with no stray trailing code. Runs of 1 to 10 identical words of each code kind, each ending with the end flag, provoke this case. A second collision is a flush that must wait for a stalled output while a different word waits at the input. The same streams are replayed under pseudo-random `out_ready`, and the bench judges both cases by comparing the received code stream with an arithmetic model of the requirements.

// File: rtl/bmrle_pkg.sv
package bmrle_pkg;
    localparam int WORD_W   = 8;
    localparam int DICT_N   = 2;
    localparam int MASK_W   = 2;
    localparam int NPOS     = WORD_W / MASK_W;
    localparam int POS_W    = $clog2(NPOS);
    localparam int IDX_W    = $clog2(DICT_N);
    localparam int CNT_W    = POS_W + IDX_W;
    localparam int CNT_MAX  = (1 << CNT_W) - 1;
    localparam int LIT_LEN  = 1 + WORD_W;
    localparam int DIR_LEN  = 2 + IDX_W;
    localparam int BM_LEN   = 2 + POS_W + MASK_W + IDX_W;
    localparam int CODE_W   = (LIT_LEN > BM_LEN) ? LIT_LEN : BM_LEN;
    localparam int LEN_W    = $clog2(CODE_W + 1);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef struct packed {
        code_t code;
        len_t  len;
    } sym_t;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_RUN,
        ST_FLUSH
    } enc_state_t;

    function automatic sym_t mk_lit(input logic [WORD_W-1:0] d);
        sym_t s;
        s.code = code_t'({1'b1, d});
        s.len  = len_t'(LIT_LEN);
        return s;
    endfunction

    function automatic sym_t mk_dir(input logic [IDX_W-1:0] idx);
        sym_t s;
        s.code = code_t'({2'b01, idx});
        s.len  = len_t'(DIR_LEN);
        return s;
    endfunction

    function automatic sym_t mk_bm(input logic [POS_W-1:0] pos,
                                   input logic [MASK_W-1:0] pat,
                                   input logic [IDX_W-1:0] idx);
        sym_t s;
        s.code = code_t'({2'b00, pos, pat, idx});
        s.len  = len_t'(BM_LEN);
        return s;
    endfunction

    function automatic sym_t mk_rle(input logic [CNT_W-1:0] cnt);
        sym_t s;
        s.code = code_t'({2'b00, cnt[CNT_W-1:IDX_W], {MASK_W{1'b0}}, cnt[IDX_W-1:0]});
        s.len  = len_t'(BM_LEN);
        return s;
    endfunction
endpackage

// File: rtl/bmrle_dict.sv
module bmrle_dict
    import bmrle_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [IDX_W-1:0]               cfg_sel,
    input  logic [WORD_W-1:0]              cfg_word,
    output logic [DICT_N-1:0][WORD_W-1:0]  entries
);
    for (genvar e = 0; e < DICT_N; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[e] <= '0;
            end else if (cfg_we && (cfg_sel == IDX_W'(e))) begin
                entries[e] <= cfg_word;
            end
        end
    end
endmodule

// File: rtl/bmrle_match.sv
module bmrle_match
    import bmrle_pkg::*;
(
    input  logic [WORD_W-1:0]              data,
    input  logic [WORD_W-1:0]              care,
    input  logic [DICT_N-1:0][WORD_W-1:0]  entries,
    output sym_t                           sym
);
    logic [DICT_N-1:0][WORD_W-1:0]             diff;
    logic [DICT_N-1:0]                         exact;
    logic [NPOS-1:0][DICT_N-1:0]               fits;
    logic [NPOS-1:0][DICT_N-1:0][MASK_W-1:0]   pat;

    for (genvar e = 0; e < DICT_N; e++) begin : g_cmp
        assign diff[e]  = (data ^ entries[e]) & care;
        assign exact[e] = (diff[e] == '0);
    end

    for (genvar p = 0; p < NPOS; p++) begin : g_pos
        localparam int LO = WORD_W - MASK_W * (p + 1);
        localparam logic [WORD_W-1:0] WIN = WORD_W'({MASK_W{1'b1}}) << LO;
        for (genvar e = 0; e < DICT_N; e++) begin : g_ent
            assign fits[p][e] = ((diff[e] & ~WIN) == '0);
            assign pat[p][e]  = diff[e][LO +: MASK_W];
        end
    end

    always_comb begin
        logic found;
        found = 1'b0;
        sym   = mk_lit(data & care);
        for (int e = 0; e < DICT_N; e++) begin
            if (!found && exact[e]) begin
                sym   = mk_dir(IDX_W'(e));
                found = 1'b1;
            end
        end
        for (int p = 0; p < NPOS; p++) begin
            for (int e = 0; e < DICT_N; e++) begin
                if (!found && fits[p][e]) begin
                    sym   = mk_bm(POS_W'(p), pat[p][e], IDX_W'(e));
                    found = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bmrle_encoder.sv
module bmrle_encoder
    import bmrle_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_sel,
    input  logic [WORD_W-1:0]  cfg_word,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_data,
    input  logic [WORD_W-1:0]  in_care,
    input  logic               in_last,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [CODE_W-1:0]  out_code,
    output logic [LEN_W-1:0]   out_len
);
    logic [DICT_N-1:0][WORD_W-1:0] entries;
    sym_t                          cur;

    enc_state_t        st, st_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    sym_t              head, head_nx;
    logic              oq_valid;
    sym_t              oq;
    logic              emit;
    sym_t              emit_sym;

    logic slot_free;
    logic is_rep;
    logic rle_wins;

    bmrle_dict u_dict (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_word (cfg_word),
        .entries  (entries)
    );

    bmrle_match u_match (
        .data    (in_data),
        .care    (in_care),
        .entries (entries),
        .sym     (cur)
    );

    assign slot_free = !oq_valid || out_ready;
    assign is_rep    = (cur == head);
    assign rle_wins  = (32'(cnt) * 32'(head.len)) > 32'(BM_LEN);

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_EMPTY;
            cnt      <= '0;
            head     <= '0;
            oq_valid <= 1'b0;
            oq       <= '0;
        end else begin
            st   <= st_nx;
            cnt  <= cnt_nx;
            head <= head_nx;
            if (emit) begin
                oq_valid <= 1'b1;
                oq       <= emit_sym;
            end else if (out_ready) begin
                oq_valid <= 1'b0;
            end
        end
    end

    // next state and outputs
    always_comb begin
        st_nx    = st;
        cnt_nx   = cnt;
        head_nx  = head;
        emit     = 1'b0;
        emit_sym = '0;
        in_ready = 1'b0;
        unique case (st)
            ST_EMPTY: begin
                in_ready = slot_free;
                if (in_valid && slot_free) begin
                    emit     = 1'b1;
                    emit_sym = cur;
                    head_nx  = cur;
                    cnt_nx   = '0;
                    st_nx    = in_last ? ST_EMPTY : ST_RUN;
                end
            end
            ST_RUN: begin
                if (is_rep) begin
                    if (cnt == CNT_W'(CNT_MAX - 1)) begin
                        in_ready = slot_free;
                        if (in_valid && slot_free) begin
                            emit     = 1'b1;
                            emit_sym = mk_rle(CNT_W'(CNT_MAX));
                            cnt_nx   = '0;
                            st_nx    = in_last ? ST_EMPTY : ST_RUN;
                        end
                    end else begin
                        in_ready = 1'b1;
                        if (in_valid) begin
                            cnt_nx = cnt + 1'b1;
                            st_nx  = in_last ? ST_FLUSH : ST_RUN;
                        end
                    end
                end else if (cnt == '0) begin
                    in_ready = slot_free;
                    if (in_valid && slot_free) begin
                        emit     = 1'b1;
                        emit_sym = cur;
                        head_nx  = cur;
                        st_nx    = in_last ? ST_EMPTY : ST_RUN;
                    end
                end else begin
                    in_ready = 1'b0;
                    if (in_valid) begin
                        st_nx = ST_FLUSH;
                    end
                end
            end
            ST_FLUSH: begin
                if (slot_free) begin
                    emit = 1'b1;
                    if (rle_wins) begin
                        emit_sym = mk_rle(cnt);
                        cnt_nx   = '0;
                        st_nx    = ST_EMPTY;
                    end else begin
                        emit_sym = head;
                        cnt_nx   = cnt - 1'b1;
                        if (cnt == CNT_W'(1)) begin
                            st_nx = ST_EMPTY;
                        end
                    end
                end
            end
            default: st_nx = ST_EMPTY;
        endcase
    end

    assign out_valid = oq_valid;
    assign out_code  = oq.code;
    assign out_len   = oq.len;
endmodule

// File: rtl/bmrle_chk.sv
module bmrle_chk
    import bmrle_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               out_valid,
    input logic               out_ready,
    input logic [CODE_W-1:0]  out_code,
    input logic [LEN_W-1:0]   out_len
);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_len)));

    assert_len_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len == LEN_W'(DIR_LEN) || out_len == LEN_W'(BM_LEN)
                       || out_len == LEN_W'(LIT_LEN)));

    assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_code >> out_len) == '0));

    assert_literal_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == LEN_W'(LIT_LEN)) |-> out_code[LIT_LEN-1]);

    assert_direct_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == LEN_W'(DIR_LEN)) |-> (out_code[DIR_LEN-1 -: 2] == 2'b01));

    assert_mask_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == LEN_W'(BM_LEN)) |-> (out_code[BM_LEN-1 -: 2] == 2'b00));

    assert_run_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == LEN_W'(BM_LEN) && out_code[IDX_W +: MASK_W] == '0)
        |-> ({out_code[IDX_W+MASK_W +: POS_W], out_code[IDX_W-1:0]} != '0));
endmodule

bind bmrle_encoder bmrle_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code),
    .out_len   (out_len)
);

// File: tb/sim_bmrle_encoder.sv
module sim_bmrle_encoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_sel = 1'b0;
    logic [7:0] cfg_word = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic [7:0] in_care = '0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [8:0] out_code;
    logic [3:0] out_len;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit bp_en  = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [7:0]  dm [2];
    logic [12:0] expq [$];
    logic [12:0] gotq [$];
    bit          have_head = 1'b0;
    logic [12:0] head_m = '0;
    int          cnt_m = 0;

    always #4 clk = ~clk;

    bmrle_encoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_word(cfg_word),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_care(in_care),
        .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_code(out_code), .out_len(out_len)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // consumer side, backpressure and watchdog
    initial begin
        forever begin
            @(negedge clk);
            out_ready = bp_en ? lfsr[0] : 1'b1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            #1;
            if (out_valid && out_ready) gotq.push_back({out_len, out_code});
            cycles++;
            if (cycles > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
                finish_run();
            end
        end
    end

    function automatic logic [12:0] ref_code(input logic [7:0] d, input logic [7:0] c);
        for (int e = 0; e < 2; e++)
            if (((d ^ dm[e]) & c) == 8'h00) return {4'd3, 9'({2'b01, 1'(e)})};
        for (int p = 0; p < 4; p++)
            for (int e = 0; e < 2; e++) begin
                logic [7:0] df;
                int sh;
                df = (d ^ dm[e]) & c;
                sh = 6 - 2 * p;
                if ((df & ~(8'h03 << sh)) == 8'h00)
                    return {4'd7, 9'({2'b00, 2'(p), 2'((df >> sh) & 8'h03), 1'(e)})};
            end
        return {4'd9, 1'b1, d & c};
    endfunction

    function automatic logic [12:0] ref_run(input int n);
        logic [2:0] v;
        v = 3'(n);
        return {4'd7, 9'({2'b00, v[2:1], 2'b00, v[0]})};
    endfunction

    function automatic void model_flush();
        if (cnt_m > 0) begin
            if (cnt_m * int'(head_m[12:9]) > 7) expq.push_back(ref_run(cnt_m));
            else for (int k = 0; k < cnt_m; k++) expq.push_back(head_m);
        end
        cnt_m = 0;
    endfunction

    function automatic void model_word(input logic [7:0] d, input logic [7:0] c, input bit l);
        logic [12:0] s;
        s = ref_code(d, c);
        if (have_head && s == head_m) begin
            cnt_m++;
            if (cnt_m == 7) begin
                expq.push_back(ref_run(7));
                cnt_m = 0;
            end
        end else begin
            model_flush();
            expq.push_back(s);
            head_m = s;
            have_head = 1'b1;
        end
        if (l) begin
            model_flush();
            have_head = 1'b0;
        end
    endfunction

    task automatic send(input logic [7:0] d, input logic [7:0] c, input bit l);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_care = c; in_last = l;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        model_word(d, c, l);
    endtask

    task automatic idle_in();
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic cfg_write(input bit sel, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_word = v;
        @(negedge clk);
        cfg_we = 1'b0;
        dm[sel] = v;
    endtask

    task automatic drain_compare(input string tag);
        int waitc = 0;
        idle_in();
        while (gotq.size() < expq.size() && waitc < 20000) begin
            @(negedge clk);
            waitc++;
        end
        repeat (20) @(negedge clk);
        checks++;
        if (gotq.size() != expq.size()) begin
            errors++;
            $display("FAIL %s code count: actual %0d expected %0d", tag, gotq.size(), expq.size());
        end
        while (expq.size() > 0 && gotq.size() > 0) begin
            logic [12:0] a, x;
            a = gotq.pop_front();
            x = expq.pop_front();
            checks++;
            if (a !== x) begin
                errors++;
                $display("FAIL %s: actual len %0d code %b expected len %0d code %b",
                         tag, a[12:9], a[8:0], x[12:9], x[8:0]);
            end
        end
        expq.delete();
        gotq.delete();
    endtask

    initial begin
        dm[0] = 8'h00; dm[1] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: reset state at the ports
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R11 reset: actual valid %b ready %b expected 0 1", out_valid, in_ready);
        end
        // R11: entries reset to zero, so word 00 is a direct hit on entry 0
        send(8'h00, 8'hFF, 1'b1);
        drain_compare("R11");

        // R10: dictionary load
        cfg_write(1'b0, 8'hA5);
        cfg_write(1'b1, 8'h3C);
        send(8'h3C, 8'hFF, 1'b0);
        send(8'hA5, 8'hFF, 1'b1);
        drain_compare("R10");

        // R1/R2/R4: all data values, full care
        for (int v = 0; v < 256; v++) send(8'(v), 8'hFF, v == 255);
        drain_compare("R1/R2/R4 sweep");

        // R3: mixed care masks
        for (int v = 0; v < 256; v++) send(8'(v * 37 + 11), 8'(v * 91 + 5), v[3]);
        drain_compare("R3 care");

        // R5/R6/R7: runs of each kind and length, ended by the end flag
        for (int k = 0; k < 3; k++)
            for (int n = 1; n <= 10; n++) begin
                logic [7:0] w;
                w = (k == 0) ? 8'hA5 : ((k == 1) ? 8'hE5 : 8'h00);
                for (int i = 0; i < n; i++) send(w, 8'hFF, i == n - 1);
                drain_compare("R5/R6/R7 run");
            end

        // R8: flush on a different word; R3 repeats through don't-care bits
        send(8'hA5, 8'hFF, 1'b0);
        send(8'h25, 8'h7F, 1'b0);
        send(8'h3C, 8'h00, 1'b0);
        send(8'hA5, 8'hFF, 1'b0);
        send(8'h00, 8'hFF, 1'b0);
        send(8'h00, 8'hFF, 1'b0);
        send(8'hE5, 8'hFF, 1'b0);
        send(8'hE5, 8'hFF, 1'b0);
        send(8'h3C, 8'hFF, 1'b1);
        send(8'h3C, 8'hFF, 1'b1);
        drain_compare("R8 R3 flush");

        // R9: same streams under backpressure
        bp_en = 1'b1;
        for (int v = 0; v < 256; v++) send(8'(v), 8'hFF, v == 255);
        drain_compare("R9 sweep");
        for (int k = 0; k < 3; k++)
            for (int n = 1; n <= 10; n++) begin
                logic [7:0] w;
                w = (k == 0) ? 8'h3C : ((k == 1) ? 8'hE5 : 8'h00);
                for (int i = 0; i < n; i++) send(w, 8'hFF, i == n - 1);
                send(8'hA5, 8'hFF, 1'b1);
            end
        drain_compare("R9 runs");
        bp_en = 1'b0;

        finish_run();
    end
endmodule